// File: doc/BRIEF.md
# Serial Configuration Master

This block loads a configuration bitstream into a programmable target device over a one-bit serial link. A controller gives a byte count and a start pulse, then streams the bitstream bytes over a valid/ready byte interface. The block takes the target through its reset handshake. It drives the active-low program line low and waits for the target to pull its open-drain init line low. It then releases the program line and waits for init to go high again. After that it shifts every byte out on the data line, most significant bit first, and the target samples each bit on the rising edge of the configuration clock.

Before each byte the block checks for a configuration error. A target that pulls init low while its done line is still low has rejected the data, and the block aborts. After the last byte the data line is held high and the configuration clock keeps running until done goes high. Every phase that waits on a target pin is bounded by a timeout. When a timeout expires, the block aborts and reports a coded reason. The width of each clock phase and the timeout length are parameters. Init and done pass through two-flop synchronizers before any use.

Top module: `scfg_master`

## Requirements
- R1: After reset and whenever idle, the outputs are: prog_n_o=1, cclk_o=0, din_o=1, busy_o=0, byte_ready_o=0. After reset, done_o=0 and err_code_o=0.
- R2: A start pulse drives prog_n_o low on the next cycle. The line stays low until the synchronized init line has been seen low. If that takes TIMEOUT_CYC cycles, the block aborts with err_code_o=1.
- R3: After prog_n_o is released, no rising CCLK edge occurs until the synchronized init line is high. If that takes TIMEOUT_CYC cycles, the block aborts with err_code_o=2 and crc_err_o=0.
- R4: Each byte produces 8 rising CCLK edges and is sent most significant bit first. DIN changes only while CCLK is low.
- R5: Every CCLK low phase lasts exactly CCLK_LO cycles. Every CCLK high phase within a run lasts at least CCLK_HI cycles.
- R6: Before each byte, while bytes remain, the block checks init and done. If init is low and done is low, it aborts with err_code_o=2 and crc_err_o=1, and it accepts no further byte.
- R7: After the last byte, DIN is 1 at every rising CCLK edge, and CCLK keeps toggling until done is high. The block then ends with done_o=1 and err_code_o=0. A length of 0 goes straight to this phase.
- R8: If done stays low for TIMEOUT_CYC cycles after the last byte, the block aborts with err_code_o=3.
- R9: byte_ready_o is high only in the load phase, with the shifter empty and bytes still owed. Exactly len_i handshakes occur in a completed run.
- R10: A start pulse while busy_o=1 is ignored: the length and the progress of the run are unchanged.
- R11: When a run ends or aborts, busy_o, prog_n_o, cclk_o and din_o return to their idle levels. done_o, err_code_o and crc_err_o hold their value until the next accepted start clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a load |
| len_i | input | LEN_W | Number of bitstream bytes, sampled with start |
| byte_data_i | input | 8 | Bitstream byte |
| byte_valid_i | input | 1 | Byte stream valid |
| byte_ready_o | output | 1 | Byte stream ready |
| prog_n_o | output | 1 | Active-low program line to the target |
| cclk_o | output | 1 | Configuration clock to the target |
| din_o | output | 1 | Serial data to the target |
| init_n_i | input | 1 | Target init line (active low, asynchronous) |
| done_i | input | 1 | Target done line (asynchronous) |
| busy_o | output | 1 | A load is in progress |
| done_o | output | 1 | Last load completed successfully |
| err_code_o | output | 2 | 0 none, 1 init-start timeout, 2 init-clear timeout or error, 3 done timeout |
| crc_err_o | output | 1 | Code 2 was caused by a data error flagged by the target |

## Verification
The hardest case to reach is the data-error abort. It requires the target to pull init low in the middle of a stream, while done is still low and between two bytes. The bench's target model does this on its own after a chosen number of received bytes. Because of the synchronizer delay, the abort may come before or after one more byte, so the check allows either count but requires that the stream stops short. The timeout cases are reached by telling the model never to drive init low, never to release it, or never to raise done.

// File: rtl/scfg_pkg.sv
package scfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PROG  = 3'd1,
    ST_WREL  = 3'd2,
    ST_LOAD  = 3'd3,
    ST_FLUSH = 3'd4
  } scfg_state_e;

  localparam logic [1:0] EC_NONE       = 2'd0;
  localparam logic [1:0] EC_INIT_START = 2'd1;
  localparam logic [1:0] EC_INIT_CLEAR = 2'd2;
  localparam logic [1:0] EC_DONE       = 2'd3;

  // error code reported when the wait in a given state times out
  function automatic logic [1:0] timeout_code(input scfg_state_e st);
    case (st)
      ST_PROG:  return EC_INIT_START;
      ST_WREL:  return EC_INIT_CLEAR;
      ST_FLUSH: return EC_DONE;
      default:  return EC_NONE;
    endcase
  endfunction

  // true for the states that wait on a target pin under a timeout
  function automatic logic is_wait_state(input scfg_state_e st);
    return (st == ST_PROG) || (st == ST_WREL) || (st == ST_FLUSH);
  endfunction

endpackage

// File: rtl/scfg_sync.sv
module scfg_sync #(
  parameter int         W       = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [1:0] ff;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff <= {2{RST_VAL[g]}};
      else        ff <= {ff[0], d_i[g]};
    end
    assign q_o[g] = ff[1];
  end

endmodule

// File: rtl/scfg_timer.sv
module scfg_timer #(
  parameter int LIMIT = 1_250_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic clr_i,
  output logic expired_o
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  assign expired_o = run_i && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clr_i || !run_i)  cnt <= '0;
    else if (!expired_o)       cnt <= cnt + CW'(1);
  end

endmodule

// File: rtl/scfg_shifter.sv
module scfg_shifter #(
  parameter int LO = 4,
  parameter int HI = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active_i,
  input  logic       flush_i,
  input  logic       load_i,
  input  logic [7:0] byte_i,
  output logic       cclk_o,
  output logic       din_o,
  output logic       empty_o
);

  localparam int PMAX = (LO > HI) ? LO : HI;
  localparam int PW   = $clog2(PMAX + 1);

  logic [7:0]    shreg;
  logic [3:0]    bits_left;
  logic [PW-1:0] pcnt;
  logic          cclk_q;
  logic          ph_end;

  // last cycle of the current clock phase
  function automatic logic phase_over(input logic lvl, input logic [PW-1:0] cnt);
    return lvl ? (cnt == PW'(HI - 1)) : (cnt == PW'(LO - 1));
  endfunction

  assign ph_end  = phase_over(cclk_q, pcnt);
  assign cclk_o  = cclk_q;
  assign din_o   = shreg[7];
  assign empty_o = (bits_left == 4'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= 8'hFF;
      bits_left <= 4'd0;
      pcnt      <= '0;
      cclk_q    <= 1'b0;
    end else if (!active_i) begin
      shreg     <= 8'hFF;
      bits_left <= 4'd0;
      pcnt      <= '0;
      cclk_q    <= 1'b0;
    end else if (flush_i) begin
      bits_left <= 4'd0;
      if (!cclk_q || ph_end) shreg <= 8'hFF;
      if (ph_end) begin
        cclk_q <= !cclk_q;
        pcnt   <= '0;
      end else begin
        pcnt <= pcnt + PW'(1);
      end
    end else if (load_i) begin
      shreg     <= byte_i;
      bits_left <= 4'd8;
      cclk_q    <= 1'b0;
      pcnt      <= '0;
    end else if (bits_left != 4'd0) begin
      if (!ph_end) begin
        pcnt <= pcnt + PW'(1);
      end else begin
        pcnt <= '0;
        if (!cclk_q) begin
          cclk_q <= 1'b1;
        end else begin
          bits_left <= bits_left - 4'd1;
          if (bits_left != 4'd1) begin
            cclk_q <= 1'b0;
            shreg  <= {shreg[6:0], 1'b1};
          end
        end
      end
    end
  end

  AST_DIN_HOLD_HI: assert property (@(posedge clk) disable iff (!rst_n) (cclk_q && $past(cclk_q)) |-> $stable(din_o)); // R4
  AST_LOAD_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) (load_i && active_i && !flush_i) |-> empty_o); // R9

endmodule

// File: rtl/scfg_master.sv
module scfg_master import scfg_pkg::*; #(
  parameter int LEN_W       = 24,
  parameter int CCLK_LO     = 4,
  parameter int CCLK_HI     = 4,
  parameter int TIMEOUT_CYC = 1_250_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [7:0]       byte_data_i,
  input  logic             byte_valid_i,
  output logic             byte_ready_o,
  output logic             prog_n_o,
  output logic             cclk_o,
  output logic             din_o,
  input  logic             init_n_i,
  input  logic             done_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [1:0]       err_code_o,
  output logic             crc_err_o
);

  scfg_state_e      state, state_nx;
  logic [LEN_W-1:0] bytes_left;
  logic             done_q, crc_q;
  logic [1:0]       err_q;

  // named internal events
  logic init_s_n, done_s;
  logic sh_empty;
  logic tmo;
  logic ld_phase;
  logic owed;
  logic crc_hit;
  logic accept;

  scfg_sync #(.W(2), .RST_VAL(2'b01)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({done_i, init_n_i}),
    .q_o   ({done_s, init_s_n})
  );

  scfg_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (is_wait_state(state)),
    .clr_i     (state_nx != state),
    .expired_o (tmo)
  );

  scfg_shifter #(.LO(CCLK_LO), .HI(CCLK_HI)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i ((state == ST_LOAD) || (state == ST_FLUSH)),
    .flush_i  (state == ST_FLUSH),
    .load_i   (accept),
    .byte_i   (byte_data_i),
    .cclk_o   (cclk_o),
    .din_o    (din_o),
    .empty_o  (sh_empty)
  );

  assign ld_phase     = (state == ST_LOAD);
  assign owed         = (bytes_left != '0);
  assign crc_hit      = ld_phase && sh_empty && owed && !init_s_n && !done_s;
  assign byte_ready_o = ld_phase && sh_empty && owed && !crc_hit;
  assign accept       = byte_valid_i && byte_ready_o;

  assign prog_n_o   = (state != ST_PROG);
  assign busy_o     = (state != ST_IDLE);
  assign done_o     = done_q;
  assign err_code_o = err_q;
  assign crc_err_o  = crc_q;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (start_i) state_nx = ST_PROG;
      ST_PROG:  if (tmo) state_nx = ST_IDLE;
                else if (!init_s_n) state_nx = ST_WREL;
      ST_WREL:  if (tmo) state_nx = ST_IDLE;
                else if (init_s_n) state_nx = ST_LOAD;
      ST_LOAD:  if (crc_hit) state_nx = ST_IDLE;
                else if (sh_empty && !owed) state_nx = ST_FLUSH;
      ST_FLUSH: if (done_s || tmo) state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      bytes_left <= '0;
      done_q     <= 1'b0;
      err_q      <= EC_NONE;
      crc_q      <= 1'b0;
    end else begin
      state <= state_nx;
      case (state)
        ST_IDLE: if (start_i) begin
          bytes_left <= len_i;
          done_q     <= 1'b0;
          err_q      <= EC_NONE;
          crc_q      <= 1'b0;
        end
        ST_LOAD: begin
          if (accept) bytes_left <= bytes_left - LEN_W'(1);
          if (crc_hit) begin
            err_q <= EC_INIT_CLEAR;
            crc_q <= 1'b1;
          end
        end
        ST_FLUSH: begin
          if (done_s)   done_q <= 1'b1;
          else if (tmo) err_q  <= timeout_code(state);
        end
        default: if (tmo) err_q <= timeout_code(state);
      endcase
    end
  end

  AST_PROG_WAITS_INIT: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_WREL && $past(state) == ST_PROG) |-> !$past(init_s_n)); // R2
  AST_NO_EARLY_CCLK: assert property (@(posedge clk) disable iff (!rst_n) $rose(cclk_o) |-> ($past(state) == ST_LOAD || $past(state) == ST_FLUSH)); // R3
  AST_FLUSH_DIN: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_FLUSH && !cclk_o) |-> din_o); // R7
  AST_CRC_CODE: assert property (@(posedge clk) disable iff (!rst_n) crc_err_o |-> (err_code_o == EC_INIT_CLEAR)); // R6
  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n) accept |=> !byte_ready_o); // R9

endmodule

// File: tb/scfg_master_tb.sv
`timescale 1ns/1ps
module scfg_master_tb_top;

  localparam int LEN_W = 16;
  localparam int LO    = 2;
  localparam int HI    = 3;
  localparam int TMO   = 400;
  localparam int TDLY  = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic start_i;
  logic [LEN_W-1:0] len_i;
  logic [7:0] byte_data_i;
  logic byte_valid_i;
  logic byte_ready_o, prog_n_o, cclk_o, din_o;
  logic init_n_i, done_i;
  logic busy_o, done_o, crc_err_o;
  logic [1:0] err_code_o;

  always #4 clk = ~clk;

  scfg_master #(.LEN_W(LEN_W), .CCLK_LO(LO), .CCLK_HI(HI), .TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
    .byte_data_i(byte_data_i), .byte_valid_i(byte_valid_i), .byte_ready_o(byte_ready_o),
    .prog_n_o(prog_n_o), .cclk_o(cclk_o), .din_o(din_o),
    .init_n_i(init_n_i), .done_i(done_i),
    .busy_o(busy_o), .done_o(done_o), .err_code_o(err_code_o), .crc_err_o(crc_err_o)
  );

  int n_chk = 0, n_fail = 0;
  int sb_chk = 0, sb_fail = 0;

  // target model knobs (written by the stimulus only)
  bit init_go_low = 1, init_go_high = 1;
  int crc_after = -1, done_after = 5, exp_bits = 0;
  byte unsigned exp_q[$];

  // target model state and observations
  int tph, tcnt, plow, early, rx_bits, rx_bytes, flush_edges, bad_flush;
  int lo_bad, hi_bad, wcnt, hs_cnt = 0;
  bit seen_fall;
  logic prev_cclk, prev_busy;
  logic [7:0] rx_sh;

  always @(posedge clk) if (byte_valid_i && byte_ready_o) hs_cnt <= hs_cnt + 1;

  // target device model plus scoreboard monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      init_n_i = 1'b1; done_i = 1'b0; prev_cclk = 1'b0; prev_busy = 1'b0; tph = 0;
    end else begin
      if (busy_o && !prev_busy) begin
        tph = 0; tcnt = 0; plow = 0; early = 0; rx_bits = 0; rx_bytes = 0;
        flush_edges = 0; bad_flush = 0; lo_bad = 0; hi_bad = 0; wcnt = 0; seen_fall = 0;
        init_n_i = 1'b1; done_i = 1'b0;
      end
      if (!busy_o && prev_busy) begin
        init_n_i = 1'b1; done_i = 1'b0;
      end
      case (tph)
        0: if (busy_o && !prog_n_o) begin tph = 1; tcnt = 0; end
        1: begin
          plow++; tcnt++;
          if (init_go_low && tcnt >= TDLY) init_n_i = 1'b0;
          if (prog_n_o) begin tph = 2; tcnt = 0; end
        end
        2: begin
          tcnt++;
          if (init_go_high && tcnt >= TDLY) begin init_n_i = 1'b1; tph = 3; end
        end
        default: ;
      endcase
      if (cclk_o && !prev_cclk) begin
        if (tph != 3) early++;
        else if (rx_bits < exp_bits) begin
          rx_sh = {rx_sh[6:0], din_o};
          rx_bits++;
          if (rx_bits % 8 == 0) begin
            rx_bytes++;
            sb_chk++;
            if (exp_q.size() == 0) begin
              sb_fail++;
              $display("FAIL R4 scoreboard: actual=%02h expected=none", rx_sh);
            end else begin
              byte unsigned e;
              e = exp_q.pop_front();
              if (rx_sh != e) begin
                sb_fail++;
                $display("FAIL R4 scoreboard byte: actual=%02h expected=%02h", rx_sh, e);
              end
            end
            if (crc_after >= 0 && rx_bytes == crc_after) init_n_i = 1'b0;
          end
        end else begin
          flush_edges++;
          if (!din_o) bad_flush++;
          if (done_after >= 0 && flush_edges >= done_after) done_i = 1'b1;
        end
      end
      if (busy_o && tph == 3) begin
        if (cclk_o != prev_cclk) begin
          if (!prev_cclk && seen_fall && wcnt != LO) lo_bad++;
          if (prev_cclk && wcnt < HI) hi_bad++;
          if (prev_cclk) seen_fall = 1;
          wcnt = 1;
        end else wcnt++;
      end
      prev_cclk = cclk_o;
      prev_busy = busy_o;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary(input int extra);
    $display("  %0d/%0d checks passed", n_chk + sb_chk - n_fail - sb_fail - extra, n_chk + sb_chk + extra);
  endtask

  function automatic byte unsigned pat(input int base, input int i);
    return 8'((base + i * 91) ^ (i << 3));
  endfunction

  task automatic run(input int n, input bit gl, input bit gh, input int crc_at, input int dn,
                     input int base, input bit bump, output int bw, output int hs);
    int h0;
    init_go_low = gl; init_go_high = gh; crc_after = crc_at; done_after = dn; exp_bits = n * 8;
    exp_q.delete();
    repeat (4) @(negedge clk);
    h0 = hs_cnt;
    len_i = LEN_W'(n); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    bw = 0;
    fork
      begin
        for (int i = 0; i < n; i++) begin
          byte_data_i = pat(base, i); byte_valid_i = 1'b1;
          exp_q.push_back(pat(base, i));
          while (hs_cnt <= h0 + i && busy_o) @(negedge clk);
          if (!busy_o) break;
        end
        byte_valid_i = 1'b0;
      end
      begin
        while (busy_o) begin bw++; @(negedge clk); end
      end
      begin
        if (bump) begin
          repeat (40) @(negedge clk);
          len_i = LEN_W'(n + 5); start_i = 1'b1;
          @(negedge clk);
          start_i = 1'b0;
        end
      end
    join
    byte_valid_i = 1'b0;
    @(negedge clk);
    hs = hs_cnt - h0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual=running expected=finished");
    summary(1);
    $finish;
  end

  initial begin
    int bw, hs;
    rst_n = 1'b0; start_i = 1'b0; len_i = '0; byte_data_i = '0; byte_valid_i = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(prog_n_o == 1 && cclk_o == 0 && din_o == 1, "R1 idle pins prog/cclk/din", {prog_n_o, cclk_o, din_o}, 3'b101);
    chk(busy_o == 0 && byte_ready_o == 0, "R1 idle busy/ready", {busy_o, byte_ready_o}, 0);
    chk(done_o == 0 && err_code_o == 0 && crc_err_o == 0, "R1 reset result", {done_o, err_code_o, crc_err_o}, 0);

    // normal load of 4 bytes
    run(4, 1, 1, -1, 5, 8'h3A, 0, bw, hs);
    chk(done_o == 1 && err_code_o == 0, "R7 success result", {done_o, err_code_o}, 3'b100);
    chk(rx_bytes == 4 && exp_q.size() == 0, "R4 bytes received", rx_bytes, 4);
    chk(hs == 4, "R9 handshake count", hs, 4);
    chk(plow >= TDLY, "R2 program held until init low", plow, TDLY);
    chk(early == 0, "R3 no clock before init release", early, 0);
    chk(bad_flush == 0 && flush_edges >= 5, "R7 flush din high", bad_flush, 0);
    chk(lo_bad == 0, "R5 low phase width", lo_bad, 0);
    chk(hi_bad == 0, "R5 high phase width", hi_bad, 0);
    chk(prog_n_o == 1 && cclk_o == 0 && busy_o == 0 && din_o == 1, "R11 idle after success", {prog_n_o, cclk_o, busy_o, din_o}, 4'b1001);

    // zero length goes straight to flush
    run(0, 1, 1, -1, 3, 0, 0, bw, hs);
    chk(done_o == 1 && err_code_o == 0 && rx_bytes == 0, "R7 zero length", rx_bytes, 0);

    // start while busy is ignored
    run(3, 1, 1, -1, 5, 8'hC4, 1, bw, hs);
    chk(hs == 3 && rx_bytes == 3, "R10 restart ignored bytes", hs, 3);
    chk(done_o == 1 && err_code_o == 0, "R10 restart ignored result", err_code_o, 0);

    // init never goes low
    run(2, 0, 1, -1, 5, 1, 0, bw, hs);
    chk(err_code_o == 1 && crc_err_o == 0, "R2 init-start timeout code", err_code_o, 1);
    chk(bw >= TMO && bw <= TMO + 2, "R2 timeout length", bw, TMO);
    chk(hs == 0 && early == 0, "R3 no bytes on start timeout", hs, 0);
    repeat (10) @(negedge clk);
    chk(err_code_o == 1 && prog_n_o == 1 && cclk_o == 0 && busy_o == 0, "R11 result held after abort", err_code_o, 1);

    // init never releases
    run(2, 1, 0, -1, 5, 2, 0, bw, hs);
    chk(err_code_o == 2 && crc_err_o == 0, "R3 init-clear timeout code", {err_code_o, crc_err_o}, 3'b100);
    chk(early == 0 && hs == 0, "R3 no clock while init low", early, 0);

    // data error reported mid stream
    run(6, 1, 1, 2, 5, 8'h5F, 0, bw, hs);
    chk(err_code_o == 2 && crc_err_o == 1, "R6 error code and flag", {err_code_o, crc_err_o}, 3'b101);
    chk(hs >= 2 && hs <= 3 && done_o == 0, "R6 stream stopped", hs, 2);

    // done never rises
    run(2, 1, 1, -1, -1, 8'h81, 0, bw, hs);
    chk(err_code_o == 3 && done_o == 0, "R8 done timeout code", err_code_o, 3);
    chk(flush_edges > 0 && bad_flush == 0, "R7 flush clocks with din high", bad_flush, 0);

    // a new start clears the old result
    run(3, 1, 1, -1, 4, 8'hF0, 0, bw, hs);
    chk(err_code_o == 0 && crc_err_o == 0 && done_o == 1, "R11 start clears result", err_code_o, 0);

    summary(0);
    $finish;
  end

endmodule